// File: doc/BRIEF.md
# Partitioned Packed-Integer SIMD Adder

This block adds or subtracts two 128-bit operands as a set of independent integer lanes. A two-bit lane-width input sets the split at run time: sixteen 8-bit lanes, eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. Every lane performs the same operation in parallel. One byte-sliced carry chain serves all four widths: at each lane boundary the incoming carry is replaced by the operation's own carry-in, so no lane ever receives a carry from its neighbour.

Each lane either wraps modulo its width or clamps at its limits. The clamp limits depend on whether the lanes hold signed or unsigned values. A per-lane flag vector shows which lanes clamped in the most recent operation. One cycle after each vector result the block also presents a 72-bit scalar. This scalar is the sum of all result lanes, each widened according to the same signed/unsigned setting. The vector result is registered and only changes on a strobed operation.

Top module: `lane_addsub_unit`

## Requirements
- R1: `lane_mode` selects the lane width: 2'b00 gives 8-bit, 2'b01 16-bit, 2'b10 32-bit and 2'b11 64-bit lanes, with lane i occupying bits [i*W +: W]. No carry or borrow passes from one lane into the next.
- R2: With `sat_en` low, each lane gives (a + b) mod 2^W when `sub_en` is low and (a - b) mod 2^W when `sub_en` is high.
- R3: With `sat_en` high and `signed_en` low, an unsigned result above 2^W-1 becomes all ones and a result below zero becomes zero.
- R4: With `sat_en` high and `signed_en` high, a two's-complement result above 2^(W-1)-1 becomes that maximum and a result below -2^(W-1) becomes that minimum.
- R5: After each operation, `sat_flags` bit i is 1 exactly when lane i clamped in that operation. Bits at or above the active lane count are 0, and every bit is 0 when `sat_en` is low.
- R6: When `in_valid` is high at a clock edge, `vec_result` and `sat_flags` take that operation's values after the edge and `res_valid` is high for one cycle. When `in_valid` is low, they hold their values and `res_valid` is low.
- R7: One cycle after `res_valid`, `red_sum` holds the 72-bit two's-complement sum of all lanes of `vec_result`, and `red_valid` is high for one cycle. Each lane is sign-extended when `signed_en` was high for that operation and zero-extended otherwise. At all other times `red_sum` holds its value.
- R8: A synchronous active-high `rst` clears `vec_result`, `sat_flags`, `red_sum`, `res_valid` and `red_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opnd_a | input | 128 | First packed operand |
| opnd_b | input | 128 | Second packed operand (subtrahend when subtracting) |
| lane_mode | input | 2 | Lane width select (00=8, 01=16, 10=32, 11=64 bits) |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| sat_en | input | 1 | 1 = saturating, 0 = wrap-around |
| signed_en | input | 1 | 1 = lanes are two's-complement |
| vec_result | output | 128 | Registered packed result |
| sat_flags | output | 16 | Per-lane clamp flags, bit i for lane i |
| res_valid | output | 1 | Vector result updated this cycle |
| red_sum | output | 72 | Horizontal sum of the result lanes |
| red_valid | output | 1 | Reduction updated this cycle |

## Verification
The bench uses all-ones bytes plus one. A design that leaks carries across lane edges would put ones into higher lanes where zeros belong. It drives lanes exactly one step past each signed and unsigned limit, in both directions. A design that takes the clamp direction from the wrong operand, or treats a subtraction borrow as a carry, would clamp to the wrong end or miss the clamp entirely. It checks reductions of all-ones lanes in both signedness settings, where zero-extension and sign-extension give very different totals, and random back-to-back streams expose a reduction that is taken from the wrong operation. It also checks that idle cycles with changing inputs leave every output untouched, and that the flags of lanes that do not exist in 64-bit mode stay clear.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

    localparam int VEC_BITS = 128;
    localparam int RED_BITS = 72;

    typedef enum logic [1:0] {
        LW_8  = 2'b00,
        LW_16 = 2'b01,
        LW_32 = 2'b10,
        LW_64 = 2'b11
    } lane_w_e;

    typedef struct packed {
        lane_w_e mode;
        logic    sub;
        logic    sat;
        logic    sgn;
    } op_ctl_t;

    // Number of bytes in one lane minus one, as a mask.
    function automatic int lane_byte_mask(lane_w_e m);
        return (1 << int'(m)) - 1;
    endfunction

    // True when byte k is the lowest byte of its lane.
    function automatic logic lane_base(int k, lane_w_e m);
        return (k & lane_byte_mask(m)) == 0;
    endfunction

endpackage

// File: rtl/lane_carry_chain.sv
module lane_carry_chain
    import simd_lane_pkg::*;
#(
    parameter int VEC_W = VEC_BITS,
    localparam int NB = VEC_W / 8
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  op_ctl_t          ctl_i,
    output logic [VEC_W-1:0] sum_o,
    output logic [NB-1:0]    cout_o,
    output logic [NB-1:0]    ovf_o
);

    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic [7:0] bx;
        logic       cin;
        logic [8:0] s9;

        assign bx = b_i[k*8 +: 8] ^ {8{ctl_i.sub}};

        if (k == 0) begin : g_first
            assign cin = ctl_i.sub;
        end else begin : g_rest
            // carry kill: a lane's lowest byte starts from the op carry-in
            assign cin = lane_base(k, ctl_i.mode) ? ctl_i.sub : cout_o[k-1];
        end

        assign s9              = {1'b0, a_i[k*8 +: 8]} + {1'b0, bx} + {8'd0, cin};
        assign sum_o[k*8 +: 8] = s9[7:0];
        assign cout_o[k]       = s9[8];
        assign ovf_o[k]        = (a_i[k*8+7] == bx[7]) && (s9[7] != a_i[k*8+7]);
    end

endmodule

// File: rtl/lane_clamp.sv
module lane_clamp
    import simd_lane_pkg::*;
#(
    parameter int VEC_W = VEC_BITS,
    localparam int NB = VEC_W / 8
) (
    input  logic [VEC_W-1:0] raw_i,
    input  logic [VEC_W-1:0] a_i,
    input  logic [NB-1:0]    cout_i,
    input  logic [NB-1:0]    ovf_i,
    input  op_ctl_t          ctl_i,
    output logic [VEC_W-1:0] res_o,
    output logic [NB-1:0]    flags_o
);

    always_comb begin
        res_o   = raw_i;
        flags_o = '0;
        for (int k = 0; k < NB; k++) begin
            int         top;
            int         lane;
            logic       u_over;
            logic       hit;
            logic       neg;
            logic [7:0] fill;
            top    = k | lane_byte_mask(ctl_i.mode);
            lane   = k >> int'(ctl_i.mode);
            // unsigned: carry out on add, missing carry (borrow) on subtract
            u_over = ctl_i.sub ? ~cout_i[top] : cout_i[top];
            hit    = ctl_i.sat && (ctl_i.sgn ? ovf_i[top] : u_over);
            neg    = a_i[top*8 + 7];
            if (!ctl_i.sgn) begin
                fill = ctl_i.sub ? 8'h00 : 8'hFF;
            end else if (k == top) begin
                fill = neg ? 8'h80 : 8'h7F;
            end else begin
                fill = neg ? 8'h00 : 8'hFF;
            end
            if (hit) begin
                res_o[k*8 +: 8] = fill;
            end
            if (k == top) begin
                flags_o[lane] = hit;
            end
        end
    end

endmodule

// File: rtl/lane_reduce.sv
module lane_reduce
    import simd_lane_pkg::*;
#(
    parameter int VEC_W = VEC_BITS,
    parameter int RED_W = RED_BITS
) (
    input  logic [VEC_W-1:0] vec_i,
    input  lane_w_e          mode_i,
    input  logic             sgn_i,
    output logic [RED_W-1:0] sum_o
);

    logic [RED_W-1:0] part [4];

    for (genvar gm = 0; gm < 4; gm++) begin : g_width
        localparam int W = 8 << gm;
        localparam int N = VEC_W / W;
        always_comb begin
            part[gm] = '0;
            for (int i = 0; i < N; i++) begin
                logic [W-1:0] ln;
                ln = vec_i[i*W +: W];
                part[gm] = part[gm] + {{(RED_W-W){sgn_i & ln[W-1]}}, ln};
            end
        end
    end

    assign sum_o = part[int'(mode_i)];

endmodule

// File: rtl/lane_addsub_unit.sv
module lane_addsub_unit
    import simd_lane_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] opnd_a,
    input  logic [127:0] opnd_b,
    input  logic [1:0]   lane_mode,
    input  logic         sub_en,
    input  logic         sat_en,
    input  logic         signed_en,
    output logic [127:0] vec_result,
    output logic [15:0]  sat_flags,
    output logic         res_valid,
    output logic [71:0]  red_sum,
    output logic         red_valid
);

    localparam int NB = VEC_BITS / 8;

    op_ctl_t             ctl;
    logic [VEC_BITS-1:0] raw_sum;
    logic [NB-1:0]       byte_cout;
    logic [NB-1:0]       byte_ovf;
    logic [VEC_BITS-1:0] clamped;
    logic [NB-1:0]       lane_hit;
    logic [RED_BITS-1:0] red_next;
    lane_w_e             mode_q;
    logic                sgn_q;

    assign ctl = '{mode: lane_w_e'(lane_mode), sub: sub_en, sat: sat_en, sgn: signed_en};

    lane_carry_chain #(.VEC_W(VEC_BITS)) chain_i (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .ctl_i  (ctl),
        .sum_o  (raw_sum),
        .cout_o (byte_cout),
        .ovf_o  (byte_ovf)
    );

    lane_clamp #(.VEC_W(VEC_BITS)) clamp_i (
        .raw_i   (raw_sum),
        .a_i     (opnd_a),
        .cout_i  (byte_cout),
        .ovf_i   (byte_ovf),
        .ctl_i   (ctl),
        .res_o   (clamped),
        .flags_o (lane_hit)
    );

    lane_reduce #(.VEC_W(VEC_BITS), .RED_W(RED_BITS)) reduce_i (
        .vec_i  (vec_result),
        .mode_i (mode_q),
        .sgn_i  (sgn_q),
        .sum_o  (red_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_result <= '0;
            sat_flags  <= '0;
            res_valid  <= 1'b0;
            mode_q     <= LW_8;
            sgn_q      <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                vec_result <= clamped;
                sat_flags  <= lane_hit;
                mode_q     <= ctl.mode;
                sgn_q      <= ctl.sgn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            red_sum   <= '0;
            red_valid <= 1'b0;
        end else begin
            red_valid <= res_valid;
            if (res_valid) begin
                red_sum <= red_next;
            end
        end
    end

endmodule

// File: rtl/lane_addsub_chk.sv
module lane_addsub_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [127:0] opnd_a,
    input logic [127:0] opnd_b,
    input logic [1:0]   lane_mode,
    input logic         sub_en,
    input logic         sat_en,
    input logic         signed_en,
    input logic [127:0] vec_result,
    input logic [15:0]  sat_flags,
    input logic         res_valid,
    input logic [71:0]  red_sum,
    input logic         red_valid
);

    a_r6_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && $stable(vec_result) && $stable(sat_flags)));

    a_r5_wrap_no_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sat_en) |=> (sat_flags == 16'h0000));

    a_r5_wide_lane_range: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_mode == 2'b11) |=> (sat_flags[15:2] == 14'h0000));

    a_r2_low_byte_wrap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_mode == 2'b00 && !sat_en && !sub_en)
        |=> (vec_result[7:0] == $past(opnd_a[7:0] + opnd_b[7:0])));

    a_r7_red_after_res: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> red_valid);

    a_r7_red_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> (!red_valid && $stable(red_sum)));

endmodule

bind lane_addsub_unit lane_addsub_chk chk_i (.*);

// File: tb/lane_addsub_unit_tb_top.sv
module lane_addsub_unit_tb_top;

    typedef struct {
        logic [127:0] vec;
        logic [15:0]  flags;
        logic [71:0]  red;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] opnd_a, opnd_b;
    logic [1:0]   lane_mode;
    logic         sub_en, sat_en, signed_en;
    logic [127:0] vec_result;
    logic [15:0]  sat_flags;
    logic         res_valid;
    logic [71:0]  red_sum;
    logic         red_valid;

    int total = 0;
    int bad   = 0;
    exp_t q_vec[$];
    logic [71:0] q_red[$];

    always #4 clk = ~clk;

    lane_addsub_unit dut_i (.*);

    function automatic exp_t model(logic [127:0] a, logic [127:0] b, logic [1:0] m,
                                   logic s, logic sat, logic sg);
        exp_t e;
        int w;
        int n;
        logic [127:0] mask;
        e.vec = '0; e.flags = '0; e.red = '0;
        w = 8 << m;
        n = 128 / w;
        mask = (128'd1 << w) - 128'd1;
        for (int i = 0; i < n; i++) begin
            logic signed [67:0] x, y, r, mx, mn, ex;
            logic [127:0] la, lb, lr;
            la = (a >> (i*w)) & mask;
            lb = (b >> (i*w)) & mask;
            x = $signed({4'b0, la[63:0]});
            y = $signed({4'b0, lb[63:0]});
            if (sg && la[w-1]) x = x - (68'sd1 <<< w);
            if (sg && lb[w-1]) y = y - (68'sd1 <<< w);
            mx = sg ? (68'sd1 <<< (w-1)) - 68'sd1 : (68'sd1 <<< w) - 68'sd1;
            mn = sg ? -(68'sd1 <<< (w-1)) : 68'sd0;
            r  = s ? x - y : x + y;
            if (sat) begin
                if (r > mx) begin r = mx; e.flags[i] = 1'b1; end
                else if (r < mn) begin r = mn; e.flags[i] = 1'b1; end
            end
            lr = {60'b0, r} & mask;
            e.vec = e.vec | (lr << (i*w));
            ex = $signed({4'b0, lr[63:0]});
            if (sg && lr[w-1]) ex = ex - (68'sd1 <<< w);
            e.red = e.red + {{4{ex[67]}}, ex};
        end
        return e;
    endfunction

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: one operation per call, starting and ending at a negedge
    task automatic do_op(logic [127:0] a, logic [127:0] b, logic [1:0] m,
                         logic s, logic sat, logic sg);
        exp_t e;
        opnd_a = a; opnd_b = b; lane_mode = m;
        sub_en = s; sat_en = sat; signed_en = sg; in_valid = 1'b1;
        e = model(a, b, m, s, sat, sg);
        q_vec.push_back(e);
        q_red.push_back(e.red);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected items as results appear
    initial begin
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            if (res_valid) begin
                if (q_vec.size() == 0) begin
                    check("R6", "unexpected res_valid", 128'd1, 128'd0);
                end else begin
                    exp_t e;
                    e = q_vec.pop_front();
                    check("R1-R4", "vec_result", vec_result, e.vec);
                    check("R5", "sat_flags", {112'd0, sat_flags}, {112'd0, e.flags});
                end
            end
            if (red_valid) begin
                if (q_red.size() == 0) begin
                    check("R7", "unexpected red_valid", 128'd1, 128'd0);
                end else begin
                    logic [71:0] er;
                    er = q_red.pop_front();
                    check("R7", "red_sum", {56'd0, red_sum}, {56'd0, er});
                end
            end
            @(negedge clk);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] held;
        rst = 1'b1; in_valid = 1'b0;
        opnd_a = '0; opnd_b = '0; lane_mode = 2'b00;
        sub_en = 0; sat_en = 0; signed_en = 0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "vec_result", vec_result, '0);
        check("R8", "flags+valids", {110'd0, sat_flags, res_valid, red_valid}, '0);
        check("R8", "red_sum", {56'd0, red_sum}, '0);
        rst = 1'b0;
        @(negedge clk);

        // R1: all-ones plus one per lane, carries must die at lane edges
        for (int m = 0; m < 4; m++) begin
            logic [127:0] ones;
            ones = '0;
            for (int i = 0; i < 128 / (8 << m); i++) ones[i*(8<<m)] = 1'b1;
            do_op({128{1'b1}}, ones, 2'(m), 1'b0, 1'b0, 1'b0);
            do_op('0, ones, 2'(m), 1'b1, 1'b0, 1'b0);
        end
        // R2: wrap add/sub mixed data
        do_op(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
              128'h8888_7777_6666_5555_4444_3333_2222_1111, 2'b01, 1'b0, 1'b0, 1'b1);
        do_op(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
              128'h8888_7777_6666_5555_4444_3333_2222_1111, 2'b10, 1'b1, 1'b0, 1'b0);
        // R3: unsigned saturation both directions
        do_op({16{8'hF0}}, {16{8'h20}}, 2'b00, 1'b0, 1'b1, 1'b0);
        do_op({8{16'h0010}}, {8{16'h0011}}, 2'b01, 1'b1, 1'b1, 1'b0);
        do_op({2{64'hFFFF_FFFF_FFFF_FFFF}}, {64'd0, 64'd1}, 2'b11, 1'b0, 1'b1, 1'b0);
        // R4: signed saturation at each limit
        do_op({4{32'h7FFF_FFFF}}, {4{32'h0000_0001}}, 2'b10, 1'b0, 1'b1, 1'b1);
        do_op({4{32'h8000_0000}}, {4{32'h0000_0001}}, 2'b10, 1'b1, 1'b1, 1'b1);
        do_op({8'h80, 8'h7F, 8'h80, 8'h7F, {12{8'h40}}},
              {8'h01, 8'hFF, 8'hFF, 8'h01, {12{8'h40}}}, 2'b00, 1'b1, 1'b1, 1'b1);
        do_op({64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
              {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001}, 2'b11, 1'b0, 1'b1, 1'b1);
        // R7: reductions of all-ones lanes, both signedness settings
        do_op({128{1'b1}}, '0, 2'b00, 1'b0, 1'b0, 1'b0);
        do_op({128{1'b1}}, '0, 2'b00, 1'b0, 1'b0, 1'b1);
        do_op({128{1'b1}}, '0, 2'b11, 1'b0, 1'b0, 1'b0);
        idle(3);

        // R6: idle cycles with changing inputs leave outputs untouched
        held = vec_result;
        opnd_a = {128{1'b1}}; opnd_b = {128{1'b1}}; sat_en = 1'b1;
        @(negedge clk);
        opnd_a = 128'h5; lane_mode = 2'b11;
        @(negedge clk);
        check("R6", "vec_result held", vec_result, held);
        check("R6", "res_valid low", {127'd0, res_valid}, '0);
        check("R7", "red_valid low", {127'd0, red_valid}, '0);

        // random streams with gaps (R1-R7)
        for (int t = 0; t < 400; t++) begin
            logic [127:0] ra, rb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            if ((t % 7) == 3) rb = ~ra;
            do_op(ra, rb, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 5) == 0) idle(1 + ($urandom % 2));
        end
        idle(4);
        check("R6", "queues drained", {64'd0, 32'(q_vec.size()), 32'(q_red.size())}, '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule